// File: doc/BRIEF.md
# Immediate-Shift Operand Barrel Shifter

This block forms the second operand of a data-processing or address calculation. It takes a register value and shifts it by an amount held in the instruction word. The instruction word supplies three fields: the index of the source register, a shift amount and a shift kind. The index goes straight back out so that the register file can fetch the operand in the same cycle. The operand, the current carry flag and a flag-update request come in alongside it. One clock edge later the block presents the shifted value, the carry bit that the shift produced, and a qualifier that says whether the carry flag should take that bit.

Four shift kinds are supported: logical left, logical right, arithmetic right and rotate right. An amount of zero does not always mean "leave the operand alone". For the two right shifts it stands for a shift by the full word width. For rotate it selects a one-bit rotate through the carry flag. The shifted value and the carry are computed on every cycle. The qualifier only tells the flag logic downstream whether to keep the new carry.

Top module: `shf_operand_shifter`

## Requirements
- R1: `reg_idx_o` equals `instr_i[3:0]` in the same cycle, with no register in between. The amount is read from `instr_i[11:7]` and the kind from `instr_i[6:5]`, where 0 = logical left, 1 = logical right, 2 = arithmetic right and 3 = rotate right.
- R2: While `rst_n` is low, `result_o`, `carry_out_o` and `carry_valid_o` are 0. After reset, the outputs show the inputs sampled at the previous rising clock edge.
- R3: For logical left by n in 1..31, the result is the operand shifted left by n with zeros filled in, and the carry is operand bit 32-n.
- R4: For logical left by 0, the result is the operand unchanged and the carry equals `carry_in_i`.
- R5: For logical right by n in 1..31, the result is the operand shifted right by n with zeros filled in, and the carry is operand bit n-1.
- R6: For logical right with an amount field of 0, the shift is taken as 32: the result is zero and the carry is operand bit 31.
- R7: For arithmetic right by n in 1..31, the vacated upper bits copy operand bit 31, and the carry is operand bit n-1.
- R8: For arithmetic right with an amount field of 0, the shift is taken as 32: every result bit and the carry equal operand bit 31.
- R9: For rotate right by n in 1..31, result bit i is operand bit (i+n) mod 32, and the carry is operand bit n-1, which is also result bit 31.
- R10: For rotate right with an amount field of 0, the result is `{carry_in_i, operand[31:1]}` and the carry is operand bit 0.
- R11: `carry_valid_o` equals `flag_upd_i` as registered one cycle earlier. `result_o` and `carry_out_o` do not depend on `flag_upd_i`.
- R12: Instruction bits outside the three fields (bit 4 and bits 31:12) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word holding the register index, shift amount and shift kind fields |
| operand_i | input | 32 | Register value to be shifted |
| carry_in_i | input | 1 | Current carry flag |
| flag_upd_i | input | 1 | Request to update the carry flag from this shift |
| reg_idx_o | output | 4 | Source register index, combinational from the instruction |
| result_o | output | 32 | Registered shifted operand |
| carry_out_o | output | 1 | Registered shifter carry |
| carry_valid_o | output | 1 | Registered flag-update qualifier |

## Verification
The clocked properties assume that the instruction, operand, carry and update inputs are known and steady around each rising edge while reset is released. They compare the registered outputs with the values those inputs had one edge earlier. The stimulus changes inputs only on falling edges and always drives defined values, including during reset. Every kind is swept against every amount from 0 to 31, using several operand patterns with the sign bit, bit 0 and alternating bits set. Random fill goes into the unused instruction bits, and the update request and incoming carry are varied alongside.

// File: rtl/shf_pkg.sv
package shf_pkg;

    // Shift kind encoding as carried in the instruction word
    typedef enum logic [1:0] {
        SHK_LSL = 2'd0,
        SHK_LSR = 2'd1,
        SHK_ASR = 2'd2,
        SHK_ROR = 2'd3
    } shf_kind_e;

    // Field positions inside the instruction word
    localparam int FLD_IDX_LO  = 0;
    localparam int FLD_KIND_LO = 5;
    localparam int FLD_AMT_LO  = 7;
    localparam int KIND_W      = 2;

endpackage

// File: rtl/shf_field_decode.sv
module shf_field_decode
    import shf_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int IDX_W   = 4,
    parameter int AMT_W   = 5
) (
    input  logic [INSTR_W-1:0] instr_i,
    output logic [IDX_W-1:0]   reg_idx_o,
    output logic [AMT_W-1:0]   amt_o,
    output shf_kind_e          kind_o
);

    localparam int AMT_HI  = FLD_AMT_LO + AMT_W - 1;
    localparam int GAP_LO  = FLD_IDX_LO + IDX_W;
    localparam int GAP_HI  = FLD_KIND_LO - 1;

    logic spare_unused;

    always_comb begin
        reg_idx_o = instr_i[FLD_IDX_LO +: IDX_W];
        amt_o     = instr_i[FLD_AMT_LO +: AMT_W];
        kind_o    = shf_kind_e'(instr_i[FLD_KIND_LO +: KIND_W]);
    end

    // Bits outside the decoded fields take no part in the shift
    assign spare_unused = ^{instr_i[INSTR_W-1:AMT_HI+1], instr_i[GAP_HI:GAP_LO]};

endmodule

// File: rtl/shf_result_path.sv
module shf_result_path
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 5
) (
    input  logic [DATA_W-1:0] op_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  shf_kind_e         kind_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o
);

    logic                     amt_zero;
    logic [AMT_W-1:0]         comp_amt;
    logic signed [DATA_W-1:0] op_s;
    logic [DATA_W-1:0]        lsl_v;
    logic [DATA_W-1:0]        lsr_v;
    logic [DATA_W-1:0]        asr_v;
    logic [DATA_W-1:0]        ror_v;

    always_comb begin
        amt_zero = (amt_i == '0);
        // Complement amount (DATA_W - n); only used when n is nonzero
        comp_amt = AMT_W'(DATA_W - int'(amt_i));
        op_s     = op_i;

        lsl_v = op_i << amt_i;

        if (amt_zero) lsr_v = '0;
        else          lsr_v = op_i >> amt_i;

        if (amt_zero) asr_v = {DATA_W{op_i[DATA_W-1]}};
        else          asr_v = op_s >>> amt_i;

        if (amt_zero) ror_v = {cin_i, op_i[DATA_W-1:1]};
        else          ror_v = (op_i >> amt_i) | (op_i << comp_amt);

        unique case (kind_i)
            SHK_LSL: res_o = lsl_v;
            SHK_LSR: res_o = lsr_v;
            SHK_ASR: res_o = asr_v;
            SHK_ROR: res_o = ror_v;
            default: res_o = op_i;
        endcase
    end

endmodule

// File: rtl/shf_carry_path.sv
module shf_carry_path
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 5
) (
    input  logic [DATA_W-1:0] op_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  shf_kind_e         kind_i,
    input  logic              cin_i,
    output logic              cout_o
);

    logic             amt_zero;
    logic [AMT_W-1:0] low_idx;
    logic [AMT_W-1:0] high_idx;
    logic             last_out_right;
    logic             last_out_left;

    always_comb begin
        amt_zero       = (amt_i == '0);
        low_idx        = amt_i - 1'b1;
        high_idx       = AMT_W'(DATA_W - int'(amt_i));
        last_out_right = op_i[low_idx];
        last_out_left  = op_i[high_idx];

        unique case (kind_i)
            SHK_LSL: cout_o = amt_zero ? cin_i             : last_out_left;
            SHK_LSR: cout_o = amt_zero ? op_i[DATA_W-1]    : last_out_right;
            SHK_ASR: cout_o = amt_zero ? op_i[DATA_W-1]    : last_out_right;
            SHK_ROR: cout_o = amt_zero ? op_i[0]           : last_out_right;
            default: cout_o = cin_i;
        endcase
    end

endmodule

// File: rtl/shf_operand_shifter.sv
module shf_operand_shifter
    import shf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int INSTR_W = 32,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  operand_i,
    input  logic               carry_in_i,
    input  logic               flag_upd_i,
    output logic [IDX_W-1:0]   reg_idx_o,
    output logic [DATA_W-1:0]  result_o,
    output logic               carry_out_o,
    output logic               carry_valid_o
);

    localparam int AMT_W = $clog2(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              cout;
        logic              cvalid;
    } shf_out_t;

    logic [AMT_W-1:0]  amt;
    shf_kind_e         kind;
    logic [DATA_W-1:0] res_c;
    logic              cout_c;
    shf_out_t          out_d;
    shf_out_t          out_q;

    shf_field_decode #(
        .INSTR_W (INSTR_W),
        .IDX_W   (IDX_W),
        .AMT_W   (AMT_W)
    ) u_decode (
        .instr_i   (instr_i),
        .reg_idx_o (reg_idx_o),
        .amt_o     (amt),
        .kind_o    (kind)
    );

    shf_result_path #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W)
    ) u_result (
        .op_i   (operand_i),
        .amt_i  (amt),
        .kind_i (kind),
        .cin_i  (carry_in_i),
        .res_o  (res_c)
    );

    shf_carry_path #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W)
    ) u_carry (
        .op_i   (operand_i),
        .amt_i  (amt),
        .kind_i (kind),
        .cin_i  (carry_in_i),
        .cout_o (cout_c)
    );

    always_comb begin
        out_d        = out_q;
        out_d.res    = res_c;
        out_d.cout   = cout_c;
        out_d.cvalid = flag_upd_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result_o      = out_q.res;
    assign carry_out_o   = out_q.cout;
    assign carry_valid_o = out_q.cvalid;

    // ---------------------------------------------------------------
    // Properties on the registered outputs against last cycle's inputs
    // ---------------------------------------------------------------
    AST_LSL_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SHK_LSL && amt == '0) |=>
            (result_o == $past(operand_i) && carry_out_o == $past(carry_in_i))); // R4

    AST_LSR_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SHK_LSR && amt != '0) |=> (result_o[DATA_W-1] == 1'b0)); // R5

    AST_LSR_ZERO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SHK_LSR && amt == '0) |=>
            (result_o == '0 && carry_out_o == $past(operand_i[DATA_W-1]))); // R6

    AST_ASR_ZERO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SHK_ASR && amt == '0) |=>
            ((result_o == '0 || result_o == '1) &&
             result_o[0] == $past(operand_i[DATA_W-1]) &&
             carry_out_o == $past(operand_i[DATA_W-1]))); // R8

    AST_ROR_CARRY_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SHK_ROR && amt != '0) |=> (carry_out_o == result_o[DATA_W-1])); // R9

    AST_RRX_CARRY_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SHK_ROR && amt == '0) |=>
            (result_o[DATA_W-1] == $past(carry_in_i) &&
             carry_out_o == $past(operand_i[0]))); // R10

    AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd_i |=> carry_valid_o); // R11

    AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_upd_i |=> !carry_valid_o); // R11

endmodule

// File: tb/tb_shf_operand_shifter.sv
`timescale 1ns/1ps
module tb_shf_operand_shifter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] operand_i = '0;
    logic        carry_in_i = 1'b0;
    logic        flag_upd_i = 1'b0;
    logic [3:0]  reg_idx_o;
    logic [31:0] result_o;
    logic        carry_out_o;
    logic        carry_valid_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [31:0] rng = 32'h1bad_5eed;

    always #4 clk = ~clk;   // 125 MHz

    shf_operand_shifter dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_i       (instr_i),
        .operand_i     (operand_i),
        .carry_in_i    (carry_in_i),
        .flag_upd_i    (flag_upd_i),
        .reg_idx_o     (reg_idx_o),
        .result_o      (result_o),
        .carry_out_o   (carry_out_o),
        .carry_valid_o (carry_valid_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // Bit-by-bit reference taken from the requirements
    task automatic model(input int ty, input int n, input logic [31:0] op, input logic cin,
                         output logic [31:0] r, output logic c);
        int eff;
        eff = (n == 0) ? 32 : n;
        r = '0;
        c = 1'b0;
        for (int i = 0; i < 32; i++) begin
            case (ty)
                0: r[i] = (n == 0) ? op[i] : ((i >= n) ? op[i-n] : 1'b0);
                1: r[i] = (i + eff < 32) ? op[i+eff] : 1'b0;
                2: r[i] = (i + eff < 32) ? op[i+eff] : op[31];
                default: r[i] = (n == 0) ? ((i == 31) ? cin : op[i+1]) : op[(i+n) % 32];
            endcase
        end
        case (ty)
            0: c = (n == 0) ? cin : op[32-n];
            1, 2: c = op[eff-1];
            default: c = (n == 0) ? op[0] : op[n-1];
        endcase
    endtask

    function automatic string tag_for(input int ty, input int n);
        case (ty)
            0: return (n == 0) ? "R4" : "R3";
            1: return (n == 0) ? "R6" : "R5";
            2: return (n == 0) ? "R8" : "R7";
            default: return (n == 0) ? "R10" : "R9";
        endcase
    endfunction

    function automatic logic [31:0] pattern(input int p, input logic [31:0] rv);
        case (p)
            0: return 32'h8000_0001;
            1: return 32'h7fff_fffe;
            2: return 32'ha5a5_3c3c;
            3: return 32'h0000_0000;
            4: return 32'hffff_ffff;
            5: return 32'h1234_5678;
            default: return rv;
        endcase
    endfunction

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Drive one vector on a falling edge, check outputs one falling edge later
    task automatic run_vec(input string tag, input int ty, input int n, input logic [31:0] op,
                           input logic cin, input logic upd, input logic [31:0] noise,
                           input logic [3:0] idx);
        logic [31:0] er;
        logic        ec;
        @(negedge clk);
        instr_i    = {noise[31:12], 5'(n), 2'(ty), noise[4], idx};
        operand_i  = op;
        carry_in_i = cin;
        flag_upd_i = upd;
        #1;
        chk("R1 reg index", {28'h0, reg_idx_o}, {28'h0, idx});
        model(ty, n, op, cin, er, ec);
        @(negedge clk);
        chk({tag, " result"}, result_o, er);
        chk({tag, " carry"}, {31'h0, carry_out_o}, {31'h0, ec});
        chk("R11 carry valid", {31'h0, carry_valid_o}, {31'h0, upd});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] er;
        logic        ec;

        // R2: outputs held at zero during reset even with busy inputs
        instr_i    = 32'hffff_ffff;
        operand_i  = 32'hdead_beef;
        carry_in_i = 1'b1;
        flag_upd_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 reset result", result_o, 32'h0);
        chk("R2 reset carry", {31'h0, carry_out_o}, 32'h0);
        chk("R2 reset valid", {31'h0, carry_valid_o}, 32'h0);
        rst_n = 1'b1;

        // R2: one-edge latency, old value visible before the edge
        @(negedge clk);
        instr_i    = {20'h0, 5'd4, 2'd1, 1'b0, 4'h0};
        operand_i  = 32'hf000_0000;
        flag_upd_i = 1'b0;
        carry_in_i = 1'b0;
        @(negedge clk);
        // latch something known, then change inputs and look before the edge
        instr_i    = {20'h0, 5'd8, 2'd0, 1'b0, 4'h0};
        operand_i  = 32'h0000_00ff;
        #1;
        chk("R2 before edge", result_o, 32'h0f00_0000);
        @(negedge clk);
        chk("R2 after edge", result_o, 32'h0000_ff00);

        // Full sweep: every kind, every amount, several operands
        for (int ty = 0; ty < 4; ty++) begin
            for (int n = 0; n < 32; n++) begin
                for (int p = 0; p < 8; p++) begin
                    rng = next_rng(rng);
                    run_vec(tag_for(ty, n), ty, n, pattern(p, rng),
                            p[0] ^ n[0], ((ty + n + p) % 3) != 0,
                            next_rng(rng ^ 32'h55aa_55aa), 4'(p + n));
                end
            end
        end

        // R12: same fields, opposite fill in the unused bits
        model(2, 7, 32'h8421_0f0f, 1'b1, er, ec);
        run_vec("R12 fill zero", 2, 7, 32'h8421_0f0f, 1'b1, 1'b1, 32'h0000_0000, 4'h9);
        chk("R12 zero-fill result", result_o, er);
        run_vec("R12 fill ones", 2, 7, 32'h8421_0f0f, 1'b1, 1'b1, 32'hffff_ffff, 4'h9);
        chk("R12 ones-fill result", result_o, er);
        model(3, 0, 32'h0000_0003, 1'b0, er, ec);
        run_vec("R12 rrx fill", 3, 0, 32'h0000_0003, 1'b0, 1'b0, 32'hffff_ffff, 4'h2);
        chk("R12 rrx carry", {31'h0, carry_out_o}, {31'h0, ec});

        done = 1'b1;
        summary();
        $finish;
    end

endmodule